// File: doc/BRIEF.md
# Indexed-Write Level Interrupt Mask Controller

This block gathers up to 1023 level-sensitive interrupt sources and reports them to one CPU. Each source has two state bits: a global enable and a CPU mask. Software never reads and rewrites a bit vector to change them. It writes the number of one source to a dedicated set or clear address, and only that source's bit changes. This makes each update a single store that cannot race with other updates.

The CPU interrupt line is high while any source is pending. A source is pending while its input is high, it is enabled and it is not masked. The handler reads an acknowledge register to learn the lowest-numbered pending source. A distinct code tells it that nothing is pending. A read-only control register reports how many sources the instance implements, so one driver can serve several sizes.

Register access uses a simple synchronous bus. A request is one cycle long. Write data is taken at the clock edge, and read data appears on the following cycle.

Top module: `irq_idx_ctrl`

## Requirements
- R1: After reset every source is disabled and masked, `irq_o` is 0 and the acknowledge register reads 0x3FF.
- R2: A write of index N to offset 0x30 sets the enable bit of source N. A write of N to offset 0x34 clears it. No other source's enable or mask bit changes.
- R3: A write of index N to offset 0x48 sets the mask bit of source N, and a write of N to offset 0x4C clears it. No other source's state changes.
- R4: A source is pending when its `src_i` bit is 1, its enable bit is 1 and its mask bit is 0. `irq_o` is the OR of all pending sources and follows `src_i` in the same cycle. It follows a register write from the edge on which the write is taken.
- R5: A read of offset 0x44 returns the number of the lowest-numbered pending source in bits [9:0], with bits [31:10] at 0.
- R6: When no source is pending, a read of offset 0x44 returns 0x3FF.
- R7: A read of offset 0x00 returns NUM_SRC in bits [11:2], with all other bits at 0.
- R8: An index write whose 32-bit data is NUM_SRC or greater changes no enable or mask bit.
- R9: Index 0 is an ordinary source. Writing 0 to 0x30 and then to 0x4C lets source 0 raise `irq_o`, and source 0 wins acknowledge over all others.
- R10: Read data appears on `rdata_o` one cycle after the read request and holds until the next read. A read of an address with no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt inputs, bit N is source N |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data (source index for index writes) |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The enable and mask bits cannot be read directly. Each one is visible only through `irq_o` and the acknowledge register. If a write sets or clears the wrong bit, `irq_o` shows it from the next edge and an acknowledge read shows it on the cycle after that. For this to work, the bench holds selected inputs high so that each bit it touches decides a pending state. A fault in the lowest-first selection is only visible with two or more pending sources. The bench therefore stacks pending sources at low, middle, top and zero indices and then removes them one at a time.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 32;
  parameter int IDX_W   = 10;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_MK_SET = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_MK_CLR = 8'h4C;

  localparam logic [IDX_W-1:0] SPURIOUS = '1;

  typedef enum logic [2:0] {
    OP_NONE, OP_EN_SET, OP_EN_CLR, OP_MK_SET, OP_MK_CLR
  } idx_op_e;
endpackage

// File: rtl/irq_idx_state.sv
module irq_idx_state
  import irq_idx_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] mask_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  idx_op_e          op;
  logic             in_range;
  logic [SEL_W-1:0] sel;
  logic [NUM_SRC-1:0] en_q, mask_q;

  assign in_range = wdata_i < DATA_W'(NUM_SRC);
  assign sel      = wdata_i[SEL_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (req_i && we_i && in_range) begin
      unique case (addr_i)
        OFS_EN_SET: op = OP_EN_SET;
        OFS_EN_CLR: op = OP_EN_CLR;
        OFS_MK_SET: op = OP_MK_SET;
        OFS_MK_CLR: op = OP_MK_CLR;
        default:    op = OP_NONE;
      endcase
    end
  end

  // one flop pair per source; only the indexed one moves
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic hit;
    assign hit = (sel == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[g]   <= 1'b0;
        mask_q[g] <= 1'b1;
      end else if (hit) begin
        if (op == OP_EN_SET) en_q[g] <= 1'b1;
        if (op == OP_EN_CLR) en_q[g] <= 1'b0;
        if (op == OP_MK_SET) mask_q[g] <= 1'b1;
        if (op == OP_MK_CLR) mask_q[g] <= 1'b0;
      end
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

  // R8
  range_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wdata_i >= DATA_W'(NUM_SRC)) |=> ($stable(en_q) && $stable(mask_q)));

  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_range && addr_i == OFS_EN_SET) |=> en_q[$past(sel)]);

  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_range && addr_i == OFS_EN_CLR) |=> !en_q[$past(sel)]);

  // R3
  mk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_range && addr_i == OFS_MK_SET) |=> mask_q[$past(sel)]);

  // R3
  mk_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_range && addr_i == OFS_MK_CLR) |=> !mask_q[$past(sel)]);

  // R2 R3: at most one bit of state changes per cycle
  single_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ($countones((en_q ^ $past(en_q)) | (mask_q ^ $past(mask_q))) <= 1));
endmodule

// File: rtl/irq_idx_pick.sv
module irq_idx_pick
  import irq_idx_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    valid_o = |pend_i;
    idx_o   = SPURIOUS;
    // scanning downward lets the lowest set bit win
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    // R5
    if (valid_o) lowest_pick_chk: assert ((pend_i & ~({NUM_SRC{1'b1}} << idx_o)) == '0);
    // R5
    if (valid_o) picked_pend_chk: assert (pend_i[idx_o]);
  end
endmodule

// File: rtl/irq_idx_ctrl.sv
module irq_idx_ctrl
  import irq_idx_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] en, mask, pend;
  logic               any_pend;
  logic [IDX_W-1:0]   pick_idx, ack_idx;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  irq_idx_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .en_o(en), .mask_o(mask)
  );

  assign pend = src_i & en & ~mask;

  irq_idx_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i(pend), .valid_o(any_pend), .idx_o(pick_idx)
  );

  assign ack_idx = any_pend ? pick_idx : SPURIOUS;
  assign irq_o   = any_pend;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFS_CTRL: rd_mux[IDX_W+1:2] = IDX_W'(NUM_SRC);
      OFS_ACK:  rd_mux[IDX_W-1:0] = ack_idx;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (req_i && !we_i)   rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R4
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((src_i & en & ~mask) != '0));

  // R6
  ack_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_ACK && !irq_o) |=> rdata_o == DATA_W'(SPURIOUS));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R7
  ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_CTRL) |=> rdata_o == DATA_W'(NUM_SRC << 2));
endmodule

// File: tb/irq_idx_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_idx_ctrl_tb_top;
  localparam int N = 64;

  logic         clk_i = 0;
  logic         rst_ni = 0;
  logic [N-1:0] src_i = '0;
  logic         req_i = 0, we_i = 0;
  logic [7:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic         irq_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  irq_idx_ctrl #(.NUM_SRC(N)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic chk_ack(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(8'h44, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq after reset", 32'(irq_o), 0);
    src_i = '1;
    @(negedge clk_i);
    chk("R1 all masked irq", 32'(irq_o), 0);
    chk_ack("R1 ack after reset", 32'h3FF);
    rd(8'h00, d);
    chk("R7 control", d, 32'(N) << 2);
    rd(8'h20, d);
    chk("R10 unmapped read", d, 0);
    @(negedge clk_i);
    chk("R10 hold", d, rdata_o);
    src_i = '0;
  endtask

  task automatic t_basic;
    src_i[5] = 1;
    wr(8'h30, 5);
    chk("R2 enabled but masked", 32'(irq_o), 0);
    wr(8'h4C, 5);
    chk("R3 unmasked irq", 32'(irq_o), 1);
    chk_ack("R5 ack single", 5);
    src_i[5] = 0;
    #0.1;
    chk("R4 level drop", 32'(irq_o), 0);
    chk_ack("R6 spurious", 32'h3FF);
    src_i[5] = 1;
    #0.1;
    chk("R4 level return", 32'(irq_o), 1);
    wr(8'h48, 5);
    chk("R3 remask", 32'(irq_o), 0);
    wr(8'h4C, 5);
    wr(8'h34, 5);
    chk("R2 disable", 32'(irq_o), 0);
    wr(8'h30, 5);
    chk("R2 re-enable", 32'(irq_o), 1);
  endtask

  task automatic t_lowest;
    src_i[9] = 1; src_i[40] = 1; src_i[6] = 1;
    wr(8'h30, 9);  wr(8'h4C, 9);
    wr(8'h30, 40); wr(8'h4C, 40);
    chk_ack("R5 lowest of 5,9,40", 5);
    chk("R2 neighbour 6 untouched", 32'(irq_o), 1);
    wr(8'h34, 5);
    chk_ack("R5 next lowest 9", 9);
    wr(8'h48, 9);
    chk_ack("R5 next lowest 40", 40);
    src_i[40] = 0;
    #0.1;
    chk("R4 none pending", 32'(irq_o), 0);
    chk_ack("R6 spurious after drop", 32'h3FF);
    src_i = '0;
  endtask

  task automatic t_range;
    src_i[63] = 1;
    wr(8'h30, 63);
    wr(8'h4C, 64);
    chk("R8 idx 64 clear-mask ignored", 32'(irq_o), 0);
    wr(8'h4C, 32'h0000_043F);
    chk("R8 high bits clear-mask ignored", 32'(irq_o), 0);
    wr(8'h4C, 63);
    chk("R3 top index unmask", 32'(irq_o), 1);
    chk_ack("R5 ack top index", 63);
    wr(8'h48, 100);
    wr(8'h34, 64);
    chk_ack("R8 set-mask/clr-enable 64+ ignored", 63);
  endtask

  task automatic t_zero;
    src_i[0] = 1;
    wr(8'h30, 0);
    chk_ack("R9 masked zero not reported", 63);
    wr(8'h4C, 0);
    chk_ack("R9 source 0 wins", 0);
    wr(8'h48, 63);
    wr(8'h34, 0);
    chk("R9 zero disabled", 32'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset;
    t_basic;
    t_lowest;
    t_range;
    t_zero;
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule